// File: doc/BRIEF.md
# Mailbox Message Transmit Fragmenter

This engine pushes a byte message into a shared-memory mailbox one 32-bit slot at a time. A request carries a byte count, a host address and a client address. The engine fetches payload bytes by offset from a byte source using a valid/ready handshake. It splits the message into fragments sized from the mailbox depth that the peer advertises. Each fragment goes out as one header slot followed by its payload slots. After each fragment the engine rings the peer's doorbell.

Before any slot is written, the engine polls the free-slot count it is given. A fragment whose peer is no longer ready afterwards spoils the whole attempt. The same applies to a ready wait or a slot wait that runs out of time, and to a depth too small to carry any payload. A spoiled attempt restarts the message from byte zero. After a bounded number of attempts the engine reports failure. A zero-length request is refused without touching the mailbox.

Top module: `msg_tx_frag`

## Requirements
- R1: A request with byte count 0 gives a one-cycle `fail_o` in the cycle after `start_i`. It raises no `irq_clr_o`, writes no slot and accepts no byte.
- R2: A request with a non-zero byte count gives a one-cycle `irq_clr_o` in the cycle after `start_i`. This comes before any slot write.
- R3: A header slot holds the following fields. Bit 31 is the last-fragment flag. Bits 30:25 are zero. Bits 24:16 hold the fragment payload length in bytes. Bits 15:8 hold the host address and bits 7:0 the client address.
- R4: The fragment limit is min(4*depth, 511) - 4 bytes. The depth is sampled when peer ready is seen at the start of each attempt. Each fragment carries min(limit, bytes left), and only the fragment that carries all the bytes left sets the last flag. A limit of 0 or below (depth under 2) spoils the attempt.
- R5: A header is written only when the free-slot count is at least 1. Payload slots are written only after the count has reached ceil(length/4). The mailbox therefore never overflows.
- R6: Payload byte k of a fragment sits in slot k/4 at bits 8*(k%4)+7 : 8*(k%4), so packing is little-endian. Unused lanes of the trailing slot are zero.
- R7: `doorbell_o` pulses for one cycle after the last slot of every fragment. Peer ready is sampled on the next cycle, and if it is low the attempt is spoiled.
- R8: A spoiled attempt restarts by waiting for peer ready, then sends again from byte offset 0. The attempt budget is MAX_TRY (5), and when the last attempt is spoiled `fail_o` pulses.
- R9: Waiting for peer ready spoils the attempt after RDY_TMO cycles. Waiting for free slots spoils it after SLOT_TMO cycles.
- R10: `byte_ready_o` is high only while payload is being packed. It stays low during every wait. `byte_addr_o` gives the message offset of the byte that is wanted.
- R11: When the last fragment is accepted, `done_o` pulses for one cycle. `done_o` and `fail_o` never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken while idle |
| len_i | input | LEN_W | Message length in bytes |
| host_addr_i | input | 8 | Host address placed in each header |
| client_addr_i | input | 8 | Client address placed in each header |
| byte_valid_i | input | 1 | Byte source has the byte at `byte_addr_o` |
| byte_data_i | input | 8 | Byte at `byte_addr_o` |
| byte_ready_o | output | 1 | Engine takes a byte this cycle if valid |
| byte_addr_o | output | LEN_W | Offset of the requested byte |
| depth_i | input | DEPTH_W | Mailbox depth in slots advertised by the peer |
| empty_slots_i | input | DEPTH_W | Free slots in the mailbox now |
| peer_ready_i | input | 1 | Peer is ready to talk |
| slot_wr_o | output | 1 | Slot write strobe |
| slot_data_o | output | 32 | Slot write data |
| doorbell_o | output | 1 | Fragment-posted interrupt to the peer |
| irq_clr_o | output | 1 | Clear pending interrupt status before sending |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | Message fully sent |
| fail_o | output | 1 | Request refused or out of attempts |

## Verification
The hardest situation to reach is a spoiled attempt partway through a message with more than one fragment, followed by a clean restart from offset 0. The bench watches the doorbell and drops peer ready for a few cycles right after the first fragment. The slot stream it then expects is that fragment followed by the complete message. Exhaustion of the slot wait is reached by stopping the mailbox drain after one depth-filling fragment. The bench then confirms that only that fragment's bytes were taken.

// File: rtl/msg_tx_pkg.sv
package msg_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RDY, ST_HDR, ST_PWAIT, ST_PAY, ST_BELL, ST_CHK
  } tx_state_e;

  localparam int unsigned FRAG_LEN_W = 9;
  localparam int unsigned LEN_CAP    = (1 << FRAG_LEN_W) - 1;

  function automatic logic [31:0] make_hdr(input logic last,
                                           input logic [FRAG_LEN_W-1:0] flen,
                                           input logic [7:0] host,
                                           input logic [7:0] client);
    return {last, 6'd0, flen, host, client};
  endfunction
endpackage

// File: rtl/msg_frag_sizer.sv
module msg_frag_sizer import msg_tx_pkg::*; #(
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned DEPTH_W = 8
) (
  input  logic [DEPTH_W-1:0]    depth_i,
  input  logic [LEN_W-1:0]      remain_i,
  output logic [FRAG_LEN_W-1:0] frag_len_o,
  output logic [7:0]            frag_slots_o,
  output logic                  frag_last_o,
  output logic                  size_ok_o
);
  logic [31:0] cap, lim, mx, rem, fl;

  always_comb begin
    cap          = 32'(depth_i) * 32'd4;
    lim          = (cap > LEN_CAP) ? LEN_CAP : cap;
    size_ok_o    = lim > 32'd4;
    mx           = size_ok_o ? lim - 32'd4 : 32'd0;
    rem          = 32'(remain_i);
    fl           = (rem <= mx) ? rem : mx;
    frag_len_o   = FRAG_LEN_W'(fl);
    frag_slots_o = 8'((fl + 32'd3) >> 2);
    frag_last_o  = size_ok_o && (rem <= mx);
  end
endmodule

// File: rtl/msg_slot_packer.sv
module msg_slot_packer (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic        flush_i,
  input  logic [1:0]  lane_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] word_o
);
  logic [31:0] word_q;

  always_comb begin
    word_o = word_q;
    word_o[8*lane_i +: 8] = byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (push_i) word_q <= flush_i ? '0 : word_o;
  end

  AST_FRESH_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && lane_i == 2'd0) |-> word_q == 32'd0); // R6
endmodule

// File: rtl/msg_wait_timer.sv
module msg_wait_timer #(
  parameter int unsigned TMO_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == limit_i - TMO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !run_i)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + TMO_W'(1);
  end

  AST_TMR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < limit_i); // R9
endmodule

// File: rtl/msg_tx_frag.sv
module msg_tx_frag import msg_tx_pkg::*; #(
  parameter int unsigned LEN_W    = 12,
  parameter int unsigned DEPTH_W  = 8,
  parameter int unsigned MAX_TRY  = 5,
  parameter int unsigned RDY_TMO  = 1024,
  parameter int unsigned SLOT_TMO = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [7:0]         host_addr_i,
  input  logic [7:0]         client_addr_i,
  input  logic               byte_valid_i,
  input  logic [7:0]         byte_data_i,
  output logic               byte_ready_o,
  output logic [LEN_W-1:0]   byte_addr_o,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [DEPTH_W-1:0] empty_slots_i,
  input  logic               peer_ready_i,
  output logic               slot_wr_o,
  output logic [31:0]        slot_data_o,
  output logic               doorbell_o,
  output logic               irq_clr_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               fail_o
);
  localparam int unsigned TRY_W = $clog2(MAX_TRY + 1);
  localparam int unsigned TMO_MAX = (RDY_TMO > SLOT_TMO) ? RDY_TMO : SLOT_TMO;
  localparam int unsigned TMO_W = $clog2(TMO_MAX + 1);

  tx_state_e              state_q, state_d;
  logic [LEN_W-1:0]       len_q, remain_q, off_q;
  logic [DEPTH_W-1:0]     depth_q;
  logic [7:0]             host_q, client_q;
  logic [TRY_W-1:0]       att_q;
  logic [FRAG_LEN_W-1:0]  fcnt_q, frag_len;
  logic [7:0]             frag_slots;
  logic                   frag_last, size_ok, hdr_q;
  logic                   push, flush, byte_end, waiting, cond, tmo, tmr_exp;
  logic                   go, rej, spoil, last_try;
  logic [31:0]            packed_word;

  msg_frag_sizer #(.LEN_W(LEN_W), .DEPTH_W(DEPTH_W)) u_sizer (
    .depth_i(depth_q), .remain_i(remain_q), .frag_len_o(frag_len),
    .frag_slots_o(frag_slots), .frag_last_o(frag_last), .size_ok_o(size_ok)
  );

  assign byte_ready_o = (state_q == ST_PAY);
  assign byte_addr_o  = off_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign push         = byte_valid_i && byte_ready_o;
  assign byte_end     = (fcnt_q + FRAG_LEN_W'(1) == frag_len);
  assign flush        = push && (fcnt_q[1:0] == 2'd3 || byte_end);
  assign last_try     = (att_q == TRY_W'(MAX_TRY));

  msg_slot_packer u_packer (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .flush_i(flush),
    .lane_i(fcnt_q[1:0]), .byte_i(byte_data_i), .word_o(packed_word)
  );

  always_comb begin
    waiting = 1'b0;
    cond    = 1'b0;
    unique case (state_q)
      ST_RDY:   begin waiting = 1'b1; cond = peer_ready_i; end
      ST_HDR:   begin waiting = 1'b1; cond = (empty_slots_i != '0); end
      ST_PWAIT: begin waiting = 1'b1; cond = (32'(empty_slots_i) >= 32'(frag_slots)); end
      default:  ;
    endcase
  end
  assign tmo = tmr_exp && !cond;

  msg_wait_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i((state_d != state_q) || spoil), .run_i(waiting),
    .limit_i((state_q == ST_RDY) ? TMO_W'(RDY_TMO) : TMO_W'(SLOT_TMO)),
    .expired_o(tmr_exp)
  );

  always_comb begin
    state_d = state_q;
    go = 1'b0; rej = 1'b0; spoil = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) begin
                  if (len_i == '0) rej = 1'b1;
                  else begin go = 1'b1; state_d = ST_RDY; end
                end
      ST_RDY:   if (peer_ready_i) state_d = ST_HDR;
                else if (tmo)     spoil = 1'b1;
      ST_HDR:   if (!size_ok)     spoil = 1'b1;
                else if (cond)    state_d = ST_PWAIT;
                else if (tmo)     spoil = 1'b1;
      ST_PWAIT: if (cond)         state_d = ST_PAY;
                else if (tmo)     spoil = 1'b1;
      ST_PAY:   if (push && byte_end) state_d = ST_BELL;
      ST_BELL:  state_d = ST_CHK;
      ST_CHK:   if (!peer_ready_i) spoil = 1'b1;
                else state_d = frag_last ? ST_IDLE : ST_HDR;
      default:  state_d = ST_IDLE;
    endcase
    if (spoil) state_d = last_try ? ST_IDLE : ST_RDY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; len_q <= '0; remain_q <= '0; off_q <= '0;
      depth_q <= '0; host_q <= '0; client_q <= '0; att_q <= '0;
      fcnt_q <= '0; hdr_q <= 1'b0; slot_wr_o <= 1'b0; slot_data_o <= '0;
      doorbell_o <= 1'b0; irq_clr_o <= 1'b0; done_o <= 1'b0; fail_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      slot_wr_o  <= 1'b0;
      hdr_q      <= 1'b0;
      doorbell_o <= 1'b0;
      irq_clr_o  <= 1'b0;
      done_o     <= 1'b0;
      fail_o     <= rej || (spoil && last_try);
      if (go) begin
        len_q <= len_i; remain_q <= len_i; off_q <= '0;
        host_q <= host_addr_i; client_q <= client_addr_i;
        att_q <= TRY_W'(1); irq_clr_o <= 1'b1;
      end
      if (state_q == ST_RDY && peer_ready_i) depth_q <= depth_i;
      if (state_q == ST_HDR && state_d == ST_PWAIT) begin
        slot_wr_o   <= 1'b1;
        hdr_q       <= 1'b1;
        slot_data_o <= make_hdr(frag_last, frag_len, host_q, client_q);
        fcnt_q      <= '0;
      end
      if (push) begin
        off_q  <= off_q + LEN_W'(1);
        fcnt_q <= fcnt_q + FRAG_LEN_W'(1);
        if (flush) begin
          slot_wr_o   <= 1'b1;
          slot_data_o <= packed_word;
        end
      end
      if (state_q == ST_BELL) doorbell_o <= 1'b1;
      if (state_q == ST_CHK && peer_ready_i) begin
        remain_q <= remain_q - LEN_W'(frag_len);
        done_o   <= frag_last;
      end
      if (spoil && !last_try) begin
        att_q <= att_q + TRY_W'(1); remain_q <= len_q; off_q <= '0;
      end
    end
  end

  AST_ZERO_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && len_i == '0) |=> (fail_o && !irq_clr_o)); // R1
  AST_CLR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && len_i != '0) |=> (irq_clr_o && !slot_wr_o)); // R2
  AST_HDR_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_wr_o && hdr_q) |-> (slot_data_o[30:25] == 6'd0 && slot_data_o[24:16] != 9'd0
                              && slot_data_o[24:16] <= 9'd507)); // R4
  AST_BELL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doorbell_o |=> !doorbell_o); // R7
  AST_TRY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_q <= TRY_W'(MAX_TRY)); // R8
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o)); // R11
endmodule

// File: tb/msg_tx_frag_tb_top.sv
module msg_tx_frag_tb_top;
  localparam int LEN_W = 12, DEPTH_W = 8, RDY_T = 40, SLOT_T = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic               start = 1'b0;
  logic [LEN_W-1:0]   len = '0;
  logic [7:0]         host = '0, client = '0;
  logic               bvalid = 1'b0;
  logic [7:0]         bdata;
  logic               bready, slot_wr, doorbell, irq_clr, busy, done, fail;
  logic [LEN_W-1:0]   baddr;
  logic [DEPTH_W-1:0] depth = 8'd8, empty;
  logic [31:0]        slot_data;
  logic               peer_en = 1'b1;
  logic [7:0]         msg_mem [0:1023];

  int fill = 0, drop_cnt = 0, cyc = 0, bells = 0, acc = 0;
  int irq_cyc = -1, first_wr = -1, res_cyc = 0;
  bit drain_en = 1'b1, drop_once = 1'b0, ovf = 1'b0, res_done = 1'b0, res_fail = 1'b0;
  bit rdy_prev = 1'b0, val_prev = 1'b0;
  int errors = 0, checks = 0, exp_frags = 0;
  logic [31:0] got_q[$], exp_q[$];

  assign bdata = msg_mem[baddr[9:0]];
  assign empty = DEPTH_W'(int'(depth) - fill);
  wire peer_rdy = peer_en && (drop_cnt == 0);

  msg_tx_frag #(.LEN_W(LEN_W), .DEPTH_W(DEPTH_W), .MAX_TRY(5),
                .RDY_TMO(RDY_T), .SLOT_TMO(SLOT_T)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len),
    .host_addr_i(host), .client_addr_i(client), .byte_valid_i(bvalid),
    .byte_data_i(bdata), .byte_ready_o(bready), .byte_addr_o(baddr),
    .depth_i(depth), .empty_slots_i(empty), .peer_ready_i(peer_rdy),
    .slot_wr_o(slot_wr), .slot_data_o(slot_data), .doorbell_o(doorbell),
    .irq_clr_o(irq_clr), .busy_o(busy), .done_o(done), .fail_o(fail)
  );

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rdy_prev && val_prev) acc++;
    if (slot_wr) begin
      got_q.push_back(slot_data);
      fill++;
      if (first_wr < 0) first_wr = cyc;
    end
    if (fill > int'(depth)) ovf = 1'b1;
    if (drain_en && fill > 0 && ($urandom % 2) == 0) fill--;
    if (doorbell) begin
      bells++;
      if (drop_once) begin drop_cnt = 10; drop_once = 1'b0; end
    end else if (drop_cnt > 0) drop_cnt--;
    if (irq_clr) irq_cyc = cyc;
    if (done) begin res_done = 1'b1; res_cyc = cyc; end
    if (fail) begin res_fail = 1'b1; res_cyc = cyc; end
    bvalid = (($urandom % 10) < 7);
    rdy_prev = bready;
    val_prev = bvalid;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic build_exp(int n, int d, logic [7:0] h, logic [7:0] c, bit first_only);
    int cap, mx, rem, off, fl, ns;
    logic [31:0] w;
    cap = d * 4;
    if (cap > 511) cap = 511;
    mx = cap - 4;
    rem = n; off = 0;
    if (mx <= 0) return;
    while (rem > 0) begin
      fl = (rem < mx) ? rem : mx;
      exp_q.push_back({(rem <= mx), 6'd0, 9'(fl), h, c});
      ns = (fl + 3) / 4;
      for (int s = 0; s < ns; s++) begin
        w = '0;
        for (int b = 0; b < 4; b++)
          if (4*s + b < fl) w[8*b +: 8] = msg_mem[off + 4*s + b];
        exp_q.push_back(w);
      end
      off += fl; rem -= fl; exp_frags++;
      if (first_only) break;
    end
  endtask

  task automatic launch(int n, int d);
    for (int i = 0; i < 1024; i++) msg_mem[i] = 8'($urandom);
    got_q.delete(); exp_q.delete();
    exp_frags = 0; bells = 0; acc = 0; ovf = 1'b0; fill = 0;
    irq_cyc = -1; first_wr = -1; res_done = 1'b0; res_fail = 1'b0;
    len = LEN_W'(n); depth = DEPTH_W'(d);
    host = 8'($urandom); client = 8'($urandom);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 40000 && !res_done && !res_fail; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_stream(string req);
    bit same;
    int bad;
    same = (got_q.size() == exp_q.size());
    bad = -1;
    if (same)
      for (int i = 0; i < got_q.size(); i++)
        if (got_q[i] !== exp_q[i] && bad < 0) bad = i;
    check(same, req, "slot count", got_q.size(), exp_q.size());
    if (same && bad >= 0)
      check(1'b0, req, $sformatf("slot %0d data", bad), got_q[bad], exp_q[bad]);
    else if (same) check(1'b1, req, "slot data", 0, 0);
  endtask

  task automatic good_run(int n, int d, bit retry);
    drop_once = retry;
    launch(n, d);
    if (retry) build_exp(n, d, host, client, 1'b1);
    build_exp(n, d, host, client, 1'b0);
    check(res_done && !res_fail, "R11", "done seen", res_done, 1);
    cmp_stream("R3 R4 R6 R8");
    check(bells == exp_frags, "R7", "doorbell count", bells, exp_frags);
    check(irq_cyc > 0 && irq_cyc < first_wr, "R2", "irq clear before first write", irq_cyc, first_wr);
    check(!ovf, "R5", "mailbox overflow", ovf, 0);
  endtask

  initial begin
    void'($urandom(32'd41057));
    for (int i = 0; i < 1024; i++) msg_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(!busy && !bready && !slot_wr && !done && !fail, "R10", "reset outputs idle",
          {busy, bready, slot_wr, done, fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 zero-length request
    launch(0, 8);
    check(res_fail && !res_done, "R1", "zero length refused", res_fail, 1);
    check(irq_cyc < 0 && got_q.size() == 0 && acc == 0, "R1", "no clear, write or byte",
          got_q.size() + acc, 0);

    // directed sizes around the fragment limit (R4)
    good_run(28, 8, 1'b0);
    good_run(29, 8, 1'b0);
    good_run(9, 2, 1'b0);
    good_run(600, 200, 1'b0);
    good_run(1, 255, 1'b0);

    // constrained random
    for (int k = 0; k < 6; k++)
      good_run(1 + int'($urandom % 700), 2 + int'($urandom % 99), 1'b0);

    // R8 peer drop after first fragment, restart from offset 0
    good_run(60, 8, 1'b1);

    // R4 depth too small for any payload
    launch(10, 1);
    check(res_fail, "R4", "depth 1 fails", res_fail, 1);
    check(got_q.size() == 0 && bells == 0, "R4", "nothing written at depth 1", got_q.size(), 0);

    // R9 peer never ready: five ready waits
    peer_en = 1'b0;
    launch(20, 8);
    check(res_fail, "R9", "ready timeout fail", res_fail, 1);
    check((res_cyc - irq_cyc) >= 5*RDY_T - 5 && (res_cyc - irq_cyc) <= 5*RDY_T + 5,
          "R9 R8", "cycles to give up", res_cyc - irq_cyc, 5*RDY_T);
    check(acc == 0 && got_q.size() == 0, "R10", "no bytes while waiting for ready", acc, 0);
    peer_en = 1'b1;

    // R9 R5 mailbox never drains
    drain_en = 1'b0;
    launch(100, 6);
    check(res_fail, "R9", "slot timeout fail", res_fail, 1);
    check(got_q.size() == 6 && !ovf, "R5", "slots written before stall", got_q.size(), 6);
    check(acc == 20, "R10", "bytes taken before stall", acc, 20);
    drain_en = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule